// File: doc/BRIEF.md
# Speed-Selectable Bus Peripheral Clock Generator

This block produces the nominal 2 MHz peripheral timing clock that a system bus carries for slow devices. It is fed by the processor clock generator. A two-bit speed setting picks how the clock is made, and that setting depends on how fast the processor runs. At the slowest processor speed the generator's peripheral clock output is already 2 MHz, so it is forwarded unchanged. At the fastest speed that same input runs at 4 MHz and is halved by a toggle flop. At the middle speed the only usable source is a 15 MHz oscillator. No integer division of 15 MHz gives 2 MHz, so a counter that restarts every 15 oscillator periods builds two output periods per restart. Their high and low stretches last 4, 4, 4 and 3 oscillator periods.

Each clock domain has its own reset synchronizer. The reset is asserted asynchronously and released on that domain's clock. The speed setting is sampled only while reset is held. The divided outputs come straight from flops, so a counter wrap cannot cause a glitch. The selected source then passes through a mux whose select is static after reset.

Top module: `pcg_bus_clk_gen`

## Requirements
- R1: With speed code 2'b00, once the peripheral-clock domain has left reset, `bus_clk_o` follows `pclk_i` level for level.
- R2: With speed code 2'b01, `bus_clk_o` goes high on the first active oscillator edge. It then repeats a 15-period cycle measured in `osc_clk_i` periods: high 4, low 4, high 4, low 3. The internal count runs 0 to 14.
- R3: With speed code 2'b10, `bus_clk_o` toggles on every active rising edge of `pclk_i`, and the first toggle drives it high.
- R4: Speed code 2'b11 is reserved, and `bus_clk_o` stays low in that mode.
- R5: While `rst_n_i` is low, `bus_clk_o` is low in every mode. Asserting `rst_n_i` forces the output low at once, without waiting for a clock edge.
- R6: `speed_i` is sampled only while a domain is in reset. Changing it after release has no effect on `bus_clk_o` until the next reset.
- R7: Reset release is synchronized per domain. The first active edge is the third rising edge of that domain's clock after `rst_n_i` rises. In mode 2'b00 the output is unblocked after the second such edge.
- R8: In mode 2'b01 the pattern counter wraps from 14 back to 0 and keeps running without pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | 15 MHz oscillator clock from the processor clock generator |
| pclk_i | input | 1 | Peripheral clock output of the processor clock generator (2 MHz or 4 MHz) |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| speed_i | input | 2 | Speed code: 00 forward, 01 oscillator pattern, 10 halve, 11 reserved |
| bus_clk_o | output | 1 | Bus peripheral clock |

## Verification
The speed input can change on the same oscillator cycle in which the pattern counter wraps from 14 to 0. That cycle is where a wrongly open mode capture would most likely derail the pattern. The bench moves `speed_i` right after the edge that completes the first 15-period cycle. It then checks `bus_clk_o` against a behavioural phase model on every following oscillator cycle; the output must not break the 4/4/4/3 sequence. A similar mid-run change in the halving mode must leave the toggle rhythm undisturbed.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic [1:0] {
    SPD_PASS  = 2'b00,
    SPD_OSC   = 2'b01,
    SPD_HALVE = 2'b10,
    SPD_RSVD  = 2'b11
  } speed_mode_e;

endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/pcg_pattern_div.sv
module pcg_pattern_div #(
  parameter int HI_A = 4,
  parameter int LO_A = 4,
  parameter int HI_B = 4,
  parameter int LO_B = 3,
  localparam int LEN  = HI_A + LO_A + HI_B + LO_B,
  localparam int CW   = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [CW-1:0] cnt_q,
  output logic          out_q
);

  localparam logic [CW-1:0] LAST    = CW'(LEN - 1);
  localparam logic [CW-1:0] B_START = CW'(HI_A + LO_A);
  localparam logic [CW-1:0] B_END   = CW'(HI_A + LO_A + HI_B);
  localparam logic [CW-1:0] A_END   = CW'(HI_A);

  logic [CW-1:0] cnt_d;
  logic          out_d;
  logic          high_now;

  assign high_now = (cnt_q < A_END) || ((cnt_q >= B_START) && (cnt_q < B_END));

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (en) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
      out_d = high_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

endmodule

// File: rtl/pcg_half_div.sv
module pcg_half_div (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic out_q
);

  logic out_d;

  always_comb begin
    out_d = out_q;
    if (en) out_d = ~out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

endmodule

// File: rtl/pcg_bus_clk_gen.sv
module pcg_bus_clk_gen
  import pcg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PAT_HI_A    = 4,
  parameter int PAT_LO_A    = 4,
  parameter int PAT_HI_B    = 4,
  parameter int PAT_LO_B    = 3
) (
  input  logic       osc_clk_i,
  input  logic       pclk_i,
  input  logic       rst_n_i,
  input  logic [1:0] speed_i,
  output logic       bus_clk_o
);

  localparam int PAT_LEN = PAT_HI_A + PAT_LO_A + PAT_HI_B + PAT_LO_B;
  localparam int PAT_CW  = $clog2(PAT_LEN);

  logic              osc_rst_s;
  logic              pclk_rst_s;
  speed_mode_e       osc_mode_q;
  speed_mode_e       pclk_mode_q;
  logic [PAT_CW-1:0] pat_cnt;
  logic              pat_q;
  logic              half_q;
  logic              pat_en;
  logic              half_en;

  pcg_rst_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk    (osc_clk_i),
    .arst_n (rst_n_i),
    .srst_n (osc_rst_s)
  );

  pcg_rst_sync #(.STAGES(SYNC_STAGES)) u_pclk_sync (
    .clk    (pclk_i),
    .arst_n (rst_n_i),
    .srst_n (pclk_rst_s)
  );

  // speed code is captured only while each domain is held in reset
  always_ff @(posedge osc_clk_i) begin
    if (!osc_rst_s) osc_mode_q <= speed_mode_e'(speed_i);
  end

  always_ff @(posedge pclk_i) begin
    if (!pclk_rst_s) pclk_mode_q <= speed_mode_e'(speed_i);
  end

  assign pat_en  = (osc_mode_q == SPD_OSC);
  assign half_en = (pclk_mode_q == SPD_HALVE);

  pcg_pattern_div #(
    .HI_A (PAT_HI_A),
    .LO_A (PAT_LO_A),
    .HI_B (PAT_HI_B),
    .LO_B (PAT_LO_B)
  ) u_pattern (
    .clk   (osc_clk_i),
    .rst_n (osc_rst_s),
    .en    (pat_en),
    .cnt_q (pat_cnt),
    .out_q (pat_q)
  );

  pcg_half_div u_half (
    .clk   (pclk_i),
    .rst_n (pclk_rst_s),
    .en    (half_en),
    .out_q (half_q)
  );

  always_comb begin
    unique case (pclk_mode_q)
      SPD_PASS:  bus_clk_o = pclk_i & pclk_rst_s;
      SPD_OSC:   bus_clk_o = pat_q;
      SPD_HALVE: bus_clk_o = half_q;
      default:   bus_clk_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcg_bus_clk_chk.sv
module pcg_bus_clk_chk
  import pcg_pkg::*;
#(
  parameter int CW          = 4,
  parameter int LAST        = 14,
  parameter int SECOND_RISE = 9
) (
  input logic          osc_clk,
  input logic          pclk,
  input logic          osc_rst_s,
  input logic          pclk_rst_s,
  input speed_mode_e   osc_mode_q,
  input speed_mode_e   pclk_mode_q,
  input logic [CW-1:0] pat_cnt,
  input logic          pat_q,
  input logic          half_q,
  input logic          bus_clk_o
);

  AST_PAT_WRAP: assert property (@(posedge osc_clk) disable iff (!osc_rst_s)
    (osc_mode_q == SPD_OSC && pat_cnt == CW'(LAST)) |=> pat_cnt == '0); // R8

  AST_PAT_STEP: assert property (@(posedge osc_clk) disable iff (!osc_rst_s)
    (osc_mode_q == SPD_OSC && pat_cnt != CW'(LAST)) |=> pat_cnt == $past(pat_cnt) + CW'(1)); // R2

  AST_PAT_RANGE: assert property (@(posedge osc_clk) disable iff (!osc_rst_s)
    pat_cnt <= CW'(LAST)); // R2

  AST_PAT_RISE_PHASE: assert property (@(posedge osc_clk) disable iff (!osc_rst_s)
    (osc_mode_q == SPD_OSC && $rose(pat_q)) |-> (pat_cnt == CW'(1) || pat_cnt == CW'(SECOND_RISE))); // R2

  AST_PAT_IDLE: assert property (@(posedge osc_clk) disable iff (!osc_rst_s)
    (osc_mode_q != SPD_OSC) |-> (!pat_q && pat_cnt == '0)); // R6

  AST_HALF_TOGGLE: assert property (@(posedge pclk) disable iff (!pclk_rst_s)
    (pclk_mode_q == SPD_HALVE && $past(pclk_rst_s)) |-> half_q != $past(half_q)); // R3

  AST_RSVD_LOW: assert property (@(posedge pclk) disable iff (!pclk_rst_s)
    (pclk_mode_q == SPD_RSVD) |-> !bus_clk_o); // R4

  AST_MODE_HELD: assert property (@(posedge pclk) disable iff (!pclk_rst_s)
    $past(pclk_rst_s) |-> $stable(pclk_mode_q)); // R6

endmodule

bind pcg_bus_clk_gen pcg_bus_clk_chk #(
  .CW          (PAT_CW),
  .LAST        (PAT_LEN - 1),
  .SECOND_RISE (PAT_HI_A + PAT_LO_A + 1)
) u_chk (
  .osc_clk     (osc_clk_i),
  .pclk        (pclk_i),
  .osc_rst_s   (osc_rst_s),
  .pclk_rst_s  (pclk_rst_s),
  .osc_mode_q  (osc_mode_q),
  .pclk_mode_q (pclk_mode_q),
  .pat_cnt     (pat_cnt),
  .pat_q       (pat_q),
  .half_q      (half_q),
  .bus_clk_o   (bus_clk_o)
);

// File: tb/pcg_bus_clk_gen_bench.sv
`timescale 1ns/1ps
module pcg_bus_clk_gen_bench;

  localparam real OSC_PERIOD  = 66.0;
  localparam real PCLK_PERIOD = 250.0;
  localparam real WATCHDOG_NS = 2000000.0;

  logic       osc_clk;
  logic       pclk;
  logic       rst_n;
  logic [1:0] speed;
  logic       bus_clk;

  int checks;
  int failures;
  bit done;

  pcg_bus_clk_gen u_pcg_bus_clk_gen (
    .osc_clk_i (osc_clk),
    .pclk_i    (pclk),
    .rst_n_i   (rst_n),
    .speed_i   (speed),
    .bus_clk_o (bus_clk)
  );

  initial begin
    osc_clk = 1'b0;
    forever #(OSC_PERIOD/2.0) osc_clk = ~osc_clk;
  end

  // offset by half a nanosecond so the two clocks never share an edge
  initial begin
    pclk = 1'b0;
    #0.5;
    forever #(PCLK_PERIOD/2.0) pclk = ~pclk;
  end

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s at %0t: bus_clk actual=%b expected=%b", req, $time, got, exp);
    end
  endtask

  // reference phase of the oscillator-derived pattern, p in 0..14
  function automatic logic pattern_level(input int p);
    return (p < 4) || (p >= 8 && p < 12);
  endfunction

  task automatic hold_reset(input logic [1:0] code);
    @(negedge osc_clk);
    rst_n = 1'b0;
    #1;
    check(bus_clk, 1'b0, "R5 async reset");
    speed = code;
    repeat (4) @(posedge pclk);
    #(PCLK_PERIOD/4.0);
    check(bus_clk, 1'b0, "R5 held reset high phase");
    @(negedge pclk);
    #(PCLK_PERIOD/4.0);
    check(bus_clk, 1'b0, "R5 held reset low phase");
    @(negedge osc_clk);
    #5;
    rst_n = 1'b1;
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 0;
    rst_n    = 1'b0;
    speed    = 2'b00;

    // R1 / R7: forward mode, speed change after release ignored (R6)
    hold_reset(2'b00);
    for (int e = 1; e <= 20; e++) begin
      @(posedge pclk);
      #(PCLK_PERIOD/4.0);
      check(bus_clk, (e >= 2) ? 1'b1 : 1'b0, "R1 R7 forward high phase");
      @(negedge pclk);
      #(PCLK_PERIOD/4.0);
      check(bus_clk, 1'b0, "R1 forward low phase");
      if (e == 10) speed = 2'b11;
    end

    // R2 / R7 / R8: oscillator pattern, speed moved on the wrap cycle (R6)
    hold_reset(2'b01);
    for (int e = 1; e <= 70; e++) begin
      int a;
      logic exp;
      @(posedge osc_clk);
      @(negedge osc_clk);
      a   = e - 2;
      exp = (a >= 1) ? pattern_level((a - 1) % 15) : 1'b0;
      check(bus_clk, exp, "R2 R8 oscillator pattern");
      if (a == 15) speed = 2'b10;
    end

    // R3 / R7: halving mode, speed change mid-run ignored (R6)
    hold_reset(2'b10);
    for (int e = 1; e <= 30; e++) begin
      int a;
      logic exp;
      @(posedge pclk);
      @(negedge pclk);
      a   = e - 2;
      exp = (a >= 1) ? logic'(a % 2) : 1'b0;
      check(bus_clk, exp, "R3 R7 halved clock");
      if (e == 9) speed = 2'b01;
    end

    // R4: reserved code keeps the output low
    hold_reset(2'b11);
    for (int e = 1; e <= 40; e++) begin
      @(negedge osc_clk);
      check(bus_clk, 1'b0, "R4 reserved low");
    end
    for (int e = 1; e <= 8; e++) begin
      @(posedge pclk);
      #(PCLK_PERIOD/4.0);
      check(bus_clk, 1'b0, "R4 reserved low at pclk high");
    end

    // R5: reset asserted mid-pattern drops the output immediately
    hold_reset(2'b01);
    repeat (4) @(posedge osc_clk);
    @(negedge osc_clk);
    check(bus_clk, 1'b1, "R2 first high stretch");
    rst_n = 1'b0;
    #1;
    check(bus_clk, 1'b0, "R5 reset mid-pattern");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at %0t: actual=hung expected=finished", $time);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule